// File: doc/BRIEF.md
# UART Channel Mode FIFO Router

This block steers bytes between a serial line, the processor's data register and a pair of byte FIFOs (receive and transmit) inside a UART. A 2-bit channel mode selects one of four routings. In normal operation line bytes fill the receive FIFO and processor writes fill the transmit FIFO. Automatic echo sends each line byte into both FIFOs. Local loopback turns processor writes back into the receive FIFO. Remote loopback sends line bytes straight back out through the transmit FIFO.

A control register holds a separate enable bit and disable bit for each direction. A direction is open only when its enable bit is set and its disable bit is clear. Two self-clearing control bits flush the FIFOs. Any byte that would enter a full FIFO is dropped and produces a one-cycle overrun pulse. The transmit FIFO drains into the serializer through a valid/ready pair. Processor reads of the data register pop the receive FIFO. The serializer, baud timing and interrupt logic sit outside this block.

Top module: `uart_chan_router`

## Requirements
- R1: The mode input encodes 0 = normal, 1 = echo, 2 = local loopback, 3 = remote loopback. A line byte (`line_valid`) is pushed into the RX FIFO in modes 0 and 1, and into the TX FIFO in modes 1 and 3.
- R2: A data register write (`dr_wr`) pushes into the TX FIFO in mode 0 and into the RX FIFO in mode 2. It has no effect on either FIFO in modes 1 and 3.
- R3: Control bit 2 is RX enable, bit 3 RX disable, bit 4 TX enable and bit 5 TX disable. A direction accepts pushes, and for RX also reads, only while its enable bit is 1 and its disable bit is 0. Gating uses the control value held before the current cycle.
- R4: A byte routed to a full RX FIFO is dropped and the stored contents are unchanged. `rx_overrun` is high for exactly the one cycle after the attempt.
- R5: A byte routed to a full TX FIFO, from the line or from the processor, is dropped. `tx_overrun` is high for exactly the one cycle after the attempt.
- R6: After a `dr_rd` cycle, `dr_rdata` holds the oldest RX byte and the RX level drops by one. If the RX FIFO is empty or RX is closed, `dr_rdata` holds 0 and the level is unchanged.
- R7: A control write with bit 0 set empties the RX FIFO, and one with bit 1 set empties the TX FIFO. Both bits read back as 0 on `ctrl_rdata`. The other control bits read back as written.
- R8: After reset, `ctrl_rdata` is 0x128 (both directions disabled), the mode is normal, both levels are 0 and both overrun outputs are 0.
- R9: Each FIFO holds DEPTH (default 64) bytes in arrival order. A push and a pop in the same cycle leave the level unchanged. A push into a full FIFO is dropped even when a pop occurs in the same cycle.
- R10: `tx_valid` is high whenever the TX FIFO is non-empty, and `tx_data` shows its oldest byte. That byte is removed on a cycle with `tx_valid` and `tx_ready` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 9 | Control write value |
| ctrl_rdata | output | 9 | Control register contents |
| mode_wr | input | 1 | Channel mode write strobe |
| mode_wdata | input | 2 | Channel mode value |
| line_valid | input | 1 | A byte has arrived from the line receiver |
| line_data | input | 8 | Received line byte |
| dr_wr | input | 1 | Processor write to the data register |
| dr_wdata | input | 8 | Processor write byte |
| dr_rd | input | 1 | Processor read of the data register |
| dr_rdata | output | 8 | Data register read result, valid the cycle after `dr_rd` |
| tx_valid | output | 1 | TX FIFO holds a byte for the serializer |
| tx_data | output | 8 | Oldest TX byte |
| tx_ready | input | 1 | Serializer takes `tx_data` |
| rx_level | output | 7 | RX FIFO fill level |
| tx_level | output | 7 | TX FIFO fill level |
| rx_overrun | output | 1 | One-cycle pulse: RX byte dropped |
| tx_overrun | output | 1 | One-cycle pulse: TX byte dropped |

## Verification
On every cycle the assertions check the following:
- no FIFO ever receives a push while full, and its level never exceeds its depth;
- each FIFO has at most one push source in any cycle;
- a flush leaves a level of zero;
- every overrun pulse follows a cycle in which the matching FIFO was full;
- a read of an empty FIFO returns zero.

The routing table itself can only be shown by the bench's scenarios: which FIFO each source lands in for every mode and enable/disable combination. The same holds for the byte ordering across a full fill and drain, and for the behaviour at the full boundary when a push and a pop meet.

// File: rtl/uart_route_pkg.sv
package uart_route_pkg;

  typedef enum logic [1:0] {
    CH_NORMAL    = 2'd0,
    CH_ECHO      = 2'd1,
    CH_LOCAL_LB  = 2'd2,
    CH_REMOTE_LB = 2'd3
  } chan_mode_e;

  localparam int CTRL_W      = 9;
  localparam int B_RX_FLUSH  = 0;
  localparam int B_TX_FLUSH  = 1;
  localparam int B_RX_EN     = 2;
  localparam int B_RX_DIS    = 3;
  localparam int B_TX_EN     = 4;
  localparam int B_TX_DIS    = 5;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h128;
  localparam logic [CTRL_W-1:0] CTRL_SELF_CLR =
    (CTRL_W'(1) << B_RX_FLUSH) | (CTRL_W'(1) << B_TX_FLUSH);

  // A direction is open only with enable set and disable clear.
  function automatic logic path_open(input logic en, input logic dis);
    return en & ~dis;
  endfunction

  function automatic logic line_feeds_rx(input chan_mode_e m);
    return (m == CH_NORMAL) || (m == CH_ECHO);
  endfunction

  function automatic logic line_feeds_tx(input chan_mode_e m);
    return (m == CH_ECHO) || (m == CH_REMOTE_LB);
  endfunction

  function automatic logic cpu_feeds_tx(input chan_mode_e m);
    return m == CH_NORMAL;
  endfunction

  function automatic logic cpu_feeds_rx(input chan_mode_e m);
    return m == CH_LOCAL_LB;
  endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [WIDTH-1:0]             wdata,
  input  logic                         pop,
  output logic [WIDTH-1:0]             rdata,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push & ~full & ~clr;
  assign do_pop  = pop & ~empty & ~clr;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  // R9
  push_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (level == LW'(DEPTH)));
  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (level == '0));

endmodule

// File: rtl/chan_router.sv
module chan_router
  import uart_route_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  chan_mode_e           mode,
  input  logic [CTRL_W-1:0]    ctrl,
  input  logic                 rx_clr,
  input  logic                 tx_clr,
  input  logic                 line_valid,
  input  logic [WIDTH-1:0]     line_data,
  input  logic                 cpu_wr,
  input  logic [WIDTH-1:0]     cpu_wdata,
  input  logic                 cpu_rd,
  input  logic                 rx_full,
  input  logic                 rx_empty,
  input  logic                 tx_full,
  output logic                 rx_push,
  output logic [WIDTH-1:0]     rx_wdata,
  output logic                 rx_pop,
  output logic                 tx_push,
  output logic [WIDTH-1:0]     tx_wdata,
  output logic                 rx_ovf_evt,
  output logic                 tx_ovf_evt
);
  logic rx_on, tx_on;
  logic line_rx_req, cpu_rx_req, line_tx_req, cpu_tx_req;
  logic rx_req, tx_req;

  assign rx_on = path_open(ctrl[B_RX_EN], ctrl[B_RX_DIS]);
  assign tx_on = path_open(ctrl[B_TX_EN], ctrl[B_TX_DIS]);

  assign line_rx_req = line_valid & line_feeds_rx(mode) & rx_on & ~rx_clr;
  assign cpu_rx_req  = cpu_wr & cpu_feeds_rx(mode) & rx_on & ~rx_clr;
  assign line_tx_req = line_valid & line_feeds_tx(mode) & tx_on & ~tx_clr;
  assign cpu_tx_req  = cpu_wr & cpu_feeds_tx(mode) & tx_on & ~tx_clr;

  assign rx_req = line_rx_req | cpu_rx_req;
  assign tx_req = line_tx_req | cpu_tx_req;

  assign rx_push    = rx_req & ~rx_full;
  assign tx_push    = tx_req & ~tx_full;
  assign rx_ovf_evt = rx_req & rx_full;
  assign tx_ovf_evt = tx_req & tx_full;
  assign rx_wdata   = line_rx_req ? line_data : cpu_wdata;
  assign tx_wdata   = line_tx_req ? line_data : cpu_wdata;
  assign rx_pop     = cpu_rd & rx_on & ~rx_empty & ~rx_clr;

  // R1
  rx_one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({line_rx_req, cpu_rx_req}));
  // R2
  tx_one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({line_tx_req, cpu_tx_req}));
  // R4
  rx_no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rx_push);
  // R5
  tx_no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !tx_push);
  // R3
  closed_rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[B_RX_DIS] || !ctrl[B_RX_EN]) |-> !(rx_push || rx_pop || rx_ovf_evt));

endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
  import uart_route_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [8:0]        ctrl_wdata,
  output logic [8:0]        ctrl_rdata,
  input  logic              mode_wr,
  input  logic [1:0]        mode_wdata,
  input  logic              line_valid,
  input  logic [WIDTH-1:0]  line_data,
  input  logic              dr_wr,
  input  logic [WIDTH-1:0]  dr_wdata,
  input  logic              dr_rd,
  output logic [WIDTH-1:0]  dr_rdata,
  output logic              tx_valid,
  output logic [WIDTH-1:0]  tx_data,
  input  logic              tx_ready,
  output logic [LW-1:0]     rx_level,
  output logic [LW-1:0]     tx_level,
  output logic              rx_overrun,
  output logic              tx_overrun
);
  logic [CTRL_W-1:0] ctrl_q;
  chan_mode_e        mode_q;
  logic              rx_clr, tx_clr;
  logic              rx_push, rx_pop, tx_push, tx_pop;
  logic [WIDTH-1:0]  rx_wdata, tx_wdata, rx_head;
  logic              rx_full, rx_empty, tx_full, tx_empty;
  logic              rx_ovf_evt, tx_ovf_evt;

  assign rx_clr = ctrl_wr & ctrl_wdata[B_RX_FLUSH];
  assign tx_clr = ctrl_wr & ctrl_wdata[B_TX_FLUSH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= CTRL_RESET;
      mode_q     <= CH_NORMAL;
      rx_overrun <= 1'b0;
      tx_overrun <= 1'b0;
      dr_rdata   <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_wdata & ~CTRL_SELF_CLR;
      if (mode_wr) mode_q <= chan_mode_e'(mode_wdata);
      rx_overrun <= rx_ovf_evt;
      tx_overrun <= tx_ovf_evt;
      if (dr_rd) dr_rdata <= rx_pop ? rx_head : '0;
    end
  end

  chan_router #(.WIDTH(WIDTH)) u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_q),
    .ctrl       (ctrl_q),
    .rx_clr     (rx_clr),
    .tx_clr     (tx_clr),
    .line_valid (line_valid),
    .line_data  (line_data),
    .cpu_wr     (dr_wr),
    .cpu_wdata  (dr_wdata),
    .cpu_rd     (dr_rd),
    .rx_full    (rx_full),
    .rx_empty   (rx_empty),
    .tx_full    (tx_full),
    .rx_push    (rx_push),
    .rx_wdata   (rx_wdata),
    .rx_pop     (rx_pop),
    .tx_push    (tx_push),
    .tx_wdata   (tx_wdata),
    .rx_ovf_evt (rx_ovf_evt),
    .tx_ovf_evt (tx_ovf_evt)
  );

  byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rx_clr),
    .push  (rx_push),
    .wdata (rx_wdata),
    .pop   (rx_pop),
    .rdata (rx_head),
    .level (rx_level),
    .full  (rx_full),
    .empty (rx_empty)
  );

  assign tx_pop = tx_ready & ~tx_empty;

  byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tx_clr),
    .push  (tx_push),
    .wdata (tx_wdata),
    .pop   (tx_pop),
    .rdata (tx_data),
    .level (tx_level),
    .full  (tx_full),
    .empty (tx_empty)
  );

  assign tx_valid   = ~tx_empty;
  assign ctrl_rdata = ctrl_q;

  // R4
  rx_overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> ($past(rx_level) == LW'(DEPTH)));
  // R5
  tx_overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overrun |-> ($past(tx_level) == LW'(DEPTH)));
  // R6
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_rd && rx_level == '0) |=> (dr_rdata == '0));
  // R7
  flush_bits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (ctrl_rdata[1:0] == 2'b00));

endmodule

// File: tb/tb_uart_chan_router.sv
`timescale 1ns/1ps
module tb_uart_chan_router;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctrl_wr;
  logic [8:0] ctrl_wdata;
  logic [8:0] ctrl_rdata;
  logic       mode_wr;
  logic [1:0] mode_wdata;
  logic       line_valid;
  logic [7:0] line_data;
  logic       dr_wr;
  logic [7:0] dr_wdata;
  logic       dr_rd;
  logic [7:0] dr_rdata;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready;
  logic [6:0] rx_level, tx_level;
  logic       rx_overrun, tx_overrun;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_chan_router dut (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .line_valid(line_valid), .line_data(line_data),
    .dr_wr(dr_wr), .dr_wdata(dr_wdata),
    .dr_rd(dr_rd), .dr_rdata(dr_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_level(rx_level), .tx_level(tx_level),
    .rx_overrun(rx_overrun), .tx_overrun(tx_overrun)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ctrl_wr = 0; mode_wr = 0; line_valid = 0; dr_wr = 0; dr_rd = 0; tx_ready = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic wr_ctrl(input logic [8:0] v);
    ctrl_wr = 1; ctrl_wdata = v; tick();
  endtask

  task automatic wr_mode(input logic [1:0] m);
    mode_wr = 1; mode_wdata = m; tick();
  endtask

  task automatic send_line(input logic [7:0] b);
    line_valid = 1; line_data = b; tick();
  endtask

  task automatic cpu_write(input logic [7:0] b);
    dr_wr = 1; dr_wdata = b; tick();
  endtask

  task automatic cpu_read();
    dr_rd = 1; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] q[$];
    logic [7:0] hd;
    int erx, etx;
    rst_n = 0; ctrl_wdata = 0; mode_wdata = 0; line_data = 0; dr_wdata = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R8 reset state
    check("R8 ctrl", ctrl_rdata, 9'h128);
    check("R8 rx_level", rx_level, 0);
    check("R8 tx_level", tx_level, 0);
    check("R8 overrun", {rx_overrun, tx_overrun}, 0);
    check("R8 tx_valid", tx_valid, 0);
    send_line(8'h11);
    check("R8 R3 closed after reset", rx_level, 0);

    // R1 R2 R3 R7 sweep: every mode x every enable/disable combination
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 16; c++) begin
        bit ron, ton;
        wr_mode(m[1:0]);
        wr_ctrl(9'(3 | (c << 2)));
        check("R7 ctrl readback", ctrl_rdata, c << 2);
        check("R7 flush", rx_level + tx_level, 0);
        ron = c[0] & ~c[1];
        ton = c[2] & ~c[3];
        erx = ((m == 0 || m == 1) && ron) ? 1 : 0;
        etx = ((m == 1 || m == 3) && ton) ? 1 : 0;
        send_line(8'(m * 16 + c));
        check("R1 R3 line->rx", rx_level, erx);
        check("R1 R3 line->tx", tx_level, etx);
        if (m == 2 && ron) erx++;
        if (m == 0 && ton) etx++;
        cpu_write(8'(c + 100));
        check("R2 R3 cpu->rx", rx_level, erx);
        check("R2 R3 cpu->tx", tx_level, etx);
      end
    end

    // R4 R9 RX full boundary, mode normal, RX open
    wr_mode(2'd0);
    wr_ctrl(9'h007);
    q.delete();
    for (int i = 0; i < DEPTH; i++) begin
      send_line(8'(i * 7 + 3));
      q.push_back(8'(i * 7 + 3));
    end
    check("R9 rx fill", rx_level, DEPTH);
    check("R4 no overrun before full", rx_overrun, 0);
    send_line(8'hEE);
    check("R4 rx_overrun pulse", rx_overrun, 1);
    check("R4 level kept", rx_level, DEPTH);
    tick();
    check("R4 pulse one cycle", rx_overrun, 0);
    // full: push + pop same cycle, push dropped
    line_valid = 1; line_data = 8'hDD; dr_rd = 1; tick();
    hd = q.pop_front();
    check("R9 full push+pop level", rx_level, DEPTH - 1);
    check("R9 R4 full push+pop overrun", rx_overrun, 1);
    check("R6 R9 head data", dr_rdata, hd);
    // not full: push + pop same cycle
    line_valid = 1; line_data = 8'hA5; dr_rd = 1; tick();
    hd = q.pop_front();
    q.push_back(8'hA5);
    check("R9 push+pop level", rx_level, DEPTH - 1);
    check("R6 R9 data", dr_rdata, hd);
    while (q.size() > 0) begin
      cpu_read();
      hd = q.pop_front();
      check("R6 R9 order", dr_rdata, hd);
    end
    check("R6 drained", rx_level, 0);
    cpu_read();
    check("R6 empty read zero", dr_rdata, 0);
    check("R6 empty level", rx_level, 0);
    // read while RX closed
    send_line(8'h5C);
    wr_ctrl(9'h00C);
    cpu_read();
    check("R6 R3 closed read zero", dr_rdata, 0);
    check("R6 R3 closed read no pop", rx_level, 1);

    // local loopback data
    wr_mode(2'd2);
    wr_ctrl(9'h005);
    cpu_write(8'h3C);
    cpu_read();
    check("R2 loopback data", dr_rdata, 8'h3C);

    // R5 R10 TX full boundary
    wr_mode(2'd0);
    wr_ctrl(9'h012);
    q.delete();
    for (int i = 0; i < DEPTH; i++) begin
      cpu_write(8'(255 - i * 3));
      q.push_back(8'(255 - i * 3));
    end
    check("R5 tx fill", tx_level, DEPTH);
    cpu_write(8'h01);
    check("R5 tx_overrun pulse", tx_overrun, 1);
    check("R5 level kept", tx_level, DEPTH);
    tick();
    check("R5 pulse one cycle", tx_overrun, 0);
    check("R10 tx_valid", tx_valid, 1);
    while (q.size() > 0) begin
      hd = q.pop_front();
      check("R10 tx order", tx_data, hd);
      tx_ready = 1; tick();
    end
    check("R10 tx drained", tx_valid, 0);

    // echo: one line byte into both FIFOs
    wr_mode(2'd1);
    wr_ctrl(9'h017);
    send_line(8'h6B);
    check("R1 echo rx", rx_level, 1);
    check("R1 R10 echo tx data", tx_data, 8'h6B);
    cpu_read();
    check("R1 echo rx data", dr_rdata, 8'h6B);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule